// File: doc/BRIEF.md
# Move-Only Processor Core

This core runs programs made of one kind of instruction: a move that carries a value from a source to a destination. No opcode tells it what to compute. The arithmetic sits on the write path of the destinations. Two accumulating registers each add whatever is written to them onto their current contents. The instruction pointer takes what is written to it as the address of the next fetch, so a jump is just a move into the instruction pointer.

A source is either accumulator or a 12-bit constant carried in the instruction word. The constant can be a plain number or the address of a label. Each instruction is fetched, decoded and retired in a single clock cycle. Programs enter a 64-word internal store through a load port while the core is held in reset.

Both accumulators and the instruction pointer are brought out as outputs so their values can be observed.

Top module: `ttm_core`

## Requirements
- R1: An instruction word is 16 bits. Bits [15:14] choose the destination: 00 accumulator A, 01 accumulator B, 10 instruction pointer, 11 discard. Bits [13:12] choose the source: 00 A, 01 B, 10 or 11 the constant. Bits [11:0] hold the constant, zero-extended to 16 bits.
- R2: A move to A sets A to its old value plus the source value, modulo 2^16.
- R3: A move to B sets B to its old value plus the source value, modulo 2^16.
- R4: A move to the instruction pointer sets it to the low 6 bits of the source value. The next instruction is fetched from that address, and A and B are unchanged.
- R5: For any destination other than the instruction pointer, the instruction pointer advances by one and wraps from 63 to 0.
- R6: A move to the discard destination changes neither A nor B.
- R7: The source is read before the destination is written, so moving A into A doubles A.
- R8: While rst_n is low, A, B and the instruction pointer are zero. Program memory keeps its contents across reset.
- R9: When load_en is high, load_word is written into program memory at load_addr on the rising clock edge. The load port is meant to be used while the core is in reset.
- R10: One move retires per clock cycle. Starting from A=0 and B=1, alternately moving B into A and then A into B gives the pairs (1,1), (1,2), (3,2), (3,5), (8,5), (8,13), (21,13).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Program store write enable |
| load_addr | input | 6 | Program store write address |
| load_word | input | 16 | Instruction word to store |
| acc_a | output | 16 | Accumulator A |
| acc_b | output | 16 | Accumulator B |
| ip | output | 6 | Instruction pointer (address of the move executed next) |

## Verification
Some paths can only be reached through program flow: the wrap of the instruction pointer from 63 to 0, the 16-bit carry-out of an accumulator, and a jump whose target comes from a register rather than a constant. A 12-bit constant alone cannot overflow an accumulator. The stimulus therefore loads a constant and doubles it through self-moves until it carries out. Another program jumps near the top of the store and lets fetch fall through to address 0. A third program places an address in A and moves A into the instruction pointer. Reset is also reasserted without reloading, to show that the stored program survives.

// File: rtl/ttm_pkg.sv
// Shared instruction layout for the move-only core.
// Assumes the 16-bit word split: destination, source kind, constant.
package ttm_pkg;
    localparam int INSTR_W = 16;
    localparam int IMM_W   = 12;

    typedef enum logic [1:0] {
        DST_A    = 2'd0,
        DST_B    = 2'd1,
        DST_IP   = 2'd2,
        DST_NONE = 2'd3
    } dst_e;

    typedef enum logic [1:0] {
        SRC_A    = 2'd0,
        SRC_B    = 2'd1,
        SRC_IMM  = 2'd2,
        SRC_IMM2 = 2'd3
    } src_e;

    typedef struct packed {
        dst_e             dst;
        src_e             src;
        logic [IMM_W-1:0] imm;
    } instr_t;
endpackage

// File: rtl/ttm_imem.sv
// Program store: one synchronous write port, one combinational read port.
// Assumes writes happen only while the core is in reset. Contents are not
// cleared by reset.
module ttm_imem #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] store [DEPTH];

    // Capture a program word from the load port.
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/ttm_srcsel.sv
// Decoder and source mux: splits the fetched word and picks the value to move.
// Assumes the accumulator inputs are the values held before this cycle's write.
module ttm_srcsel
    import ttm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [INSTR_W-1:0] word,
    input  logic [DATA_W-1:0]  acc_a,
    input  logic [DATA_W-1:0]  acc_b,
    output dst_e               dst,
    output logic [DATA_W-1:0]  src_val
);
    instr_t ins;
    assign ins = instr_t'(word);
    assign dst = ins.dst;

    // Choose the moved value from the source kind.
    always_comb begin
        unique case (ins.src)
            SRC_A:   src_val = acc_a;
            SRC_B:   src_val = acc_b;
            default: src_val = {{(DATA_W-IMM_W){1'b0}}, ins.imm};
        endcase
    end
endmodule

// File: rtl/ttm_acc.sv
// Accumulating destination register: each write adds the incoming value.
// Assumes wrap-around arithmetic; no flags are kept.
module ttm_acc #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    // Clear on reset, otherwise add the incoming value on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            q <= q + din;
        end
    end
endmodule

// File: rtl/ttm_core.sv
// Move-only core: fetch, decode and retire one move per clock.
// Writes to A/B accumulate; a write to the instruction pointer is a jump.
// Assumes the program is loaded while rst_n is low.
module ttm_core
    import ttm_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [AW-1:0]      load_addr,
    input  logic [INSTR_W-1:0] load_word,
    output logic [DATA_W-1:0]  acc_a,
    output logic [DATA_W-1:0]  acc_b,
    output logic [AW-1:0]      ip
);
    logic [AW-1:0]      ip_q;
    logic [INSTR_W-1:0] fetched;
    dst_e               dec_dst;
    logic [DATA_W-1:0]  src_val;
    logic [DATA_W-1:0]  acc_q [2];

    ttm_imem #(
        .DEPTH  (DEPTH),
        .WORD_W (INSTR_W)
    ) u_imem (
        .clk   (clk),
        .we    (load_en),
        .waddr (load_addr),
        .wdata (load_word),
        .raddr (ip_q),
        .rdata (fetched)
    );

    ttm_srcsel #(
        .DATA_W (DATA_W)
    ) u_srcsel (
        .word    (fetched),
        .acc_a   (acc_q[0]),
        .acc_b   (acc_q[1]),
        .dst     (dec_dst),
        .src_val (src_val)
    );

    for (genvar g = 0; g < 2; g++) begin : g_acc
        ttm_acc #(
            .DATA_W (DATA_W)
        ) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (dec_dst == ((g == 0) ? DST_A : DST_B)),
            .din   (src_val),
            .q     (acc_q[g])
        );
    end

    // Advance the instruction pointer, or jump to the moved value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q <= '0;
        end else if (dec_dst == DST_IP) begin
            ip_q <= src_val[AW-1:0];
        end else begin
            ip_q <= ip_q + 1'b1;
        end
    end

    assign acc_a = acc_q[0];
    assign acc_b = acc_q[1];
    assign ip    = ip_q;
endmodule

// File: rtl/ttm_core_chk.sv
// Property checker for ttm_core, attached through bind.
// Assumes dst and src_val are the decoded fields of the word being retired.
module ttm_core_chk #(
    parameter int DATA_W = 16,
    parameter int AW     = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] acc_a,
    input logic [DATA_W-1:0] acc_b,
    input logic [AW-1:0]     ip,
    input logic [1:0]        dst,
    input logic [DATA_W-1:0] src_val
);
    a_r2_acc_a_sum: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dst) == 2'd0) |-> acc_a == $past(acc_a) + $past(src_val));

    a_r3_acc_b_sum: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dst) == 2'd1) |-> acc_b == $past(acc_b) + $past(src_val));

    a_r4_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dst) == 2'd2) |-> ip == $past(src_val[AW-1:0]));

    a_r5_ip_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dst) != 2'd2) |-> ip == $past(ip) + 1'b1);

    a_r6_discard_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dst) == 2'd3) |-> ($stable(acc_a) && $stable(acc_b)));

    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (acc_a == '0 && acc_b == '0 && ip == '0));
endmodule

bind ttm_core ttm_core_chk #(
    .DATA_W (DATA_W),
    .AW     (AW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_a   (acc_a),
    .acc_b   (acc_b),
    .ip      (ip),
    .dst     (dec_dst),
    .src_val (src_val)
);

// File: tb/ttm_core_bench.sv
// Bench for ttm_core: a behavioural reference model runs in step with the
// core and is compared every cycle, plus hand-computed checkpoints.
module ttm_core_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [15:0] load_word = '0;
    logic [15:0] acc_a;
    logic [15:0] acc_b;
    logic [5:0]  ip;

    int checks = 0;
    int failures = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // Reference model state
    logic [15:0] m_mem [64];
    logic [15:0] m_a = '0;
    logic [15:0] m_b = '0;
    logic [5:0]  m_ip = '0;
    logic [15:0] prog [64];

    ttm_core u_ttm_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_word (load_word),
        .acc_a     (acc_a),
        .acc_b     (acc_b),
        .ip        (ip)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: execute one move per edge, or clear while in reset.
    always @(posedge clk) begin
        logic [15:0] w;
        logic [15:0] s;
        if (!rst_n) begin
            m_a = '0; m_b = '0; m_ip = '0;
        end else begin
            w = m_mem[m_ip];
            if (w[13:12] == 2'd0) s = m_a;
            else if (w[13:12] == 2'd1) s = m_b;
            else s = {4'h0, w[11:0]};
            if (w[15:14] == 2'd0) m_a = m_a + s;
            if (w[15:14] == 2'd1) m_b = m_b + s;
            if (w[15:14] == 2'd2) m_ip = s[5:0];
            else m_ip = m_ip + 6'd1;
        end
        if (load_en) m_mem[load_addr] = load_word;
    end

    // Lockstep comparison away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (acc_a !== m_a || acc_b !== m_b || ip !== m_ip) begin
                failures++;
                $display("FAIL lockstep R2 R3 R4 R5: A=%h B=%h IP=%0d expected A=%h B=%h IP=%0d",
                         acc_a, acc_b, ip, m_a, m_b, m_ip);
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) prog[i] = 16'hC000;
    endtask

    // R9: load the whole store through the load port while in reset.
    task automatic load_prog();
        load_en = 1'b1;
        for (int i = 0; i < 64; i++) begin
            load_addr = i[5:0];
            load_word = prog[i];
            @(negedge clk);
        end
        load_en = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        step(2);
        cmp_on = 1'b1;
        chk("R8 reset A", acc_a, 16'h0);
        chk("R8 reset IP", {10'h0, ip}, 16'h0);

        // Program: doubling, carry-out, discard, jump near the top, wrap.
        clear_prog();
        prog[0] = 16'h2003;                          // A += 3
        prog[1] = 16'h0000;                          // A += A
        prog[2] = 16'h6FFF;                          // B += 0xFFF
        for (int i = 3; i < 8; i++) prog[i] = 16'h5000; // B += B
        prog[8]  = 16'h7020;                         // B += 0x20 (source kind 11)
        prog[9]  = 16'hE555;                         // discard
        prog[10] = 16'hA03C;                         // IP <= 60
        prog[11] = 16'h2001;                         // skipped
        load_prog();
        rst_n = 1'b1;
        step(2);  chk("R7 self-move doubles A", acc_a, 16'h0006);
        step(6);  chk("R3 B wraps mod 2^16", acc_b, 16'hFFE0);
        step(1);  chk("R1 source kind 11 is constant", acc_b, 16'h0000);
        step(1);  chk("R6 discard keeps A", acc_a, 16'h0006);
                  chk("R6 discard keeps B", acc_b, 16'h0000);
        step(1);  chk("R4 constant jump", {10'h0, ip}, 16'd60);
                  chk("R4 jump leaves A", acc_a, 16'h0006);
        step(4);  chk("R5 IP wraps 63 to 0", {10'h0, ip}, 16'd0);
        step(1);  chk("R2 A accumulates after wrap", acc_a, 16'h0009);

        // Program: alternating accumulation sequence.
        rst_n = 1'b0;
        step(1);
        chk("R8 reset clears B", acc_b, 16'h0);
        clear_prog();
        prog[0] = 16'h6001;                          // B += 1
        prog[1] = 16'h1000;                          // A += B
        prog[2] = 16'h4000;                          // B += A
        prog[3] = 16'hA001;                          // IP <= 1
        load_prog();
        rst_n = 1'b1;
        step(2); chk("R10 pair1 A", acc_a, 16'd1);  chk("R10 pair1 B", acc_b, 16'd1);
        step(1); chk("R10 pair2 A", acc_a, 16'd1);  chk("R10 pair2 B", acc_b, 16'd2);
        step(2); chk("R10 pair3 A", acc_a, 16'd3);  chk("R10 pair3 B", acc_b, 16'd2);
        step(1); chk("R10 pair4 A", acc_a, 16'd3);  chk("R10 pair4 B", acc_b, 16'd5);
        step(2); chk("R10 pair5 A", acc_a, 16'd8);  chk("R10 pair5 B", acc_b, 16'd5);
        step(1); chk("R10 pair6 A", acc_a, 16'd8);  chk("R10 pair6 B", acc_b, 16'd13);
        step(2); chk("R10 pair7 A", acc_a, 16'd21); chk("R10 pair7 B", acc_b, 16'd13);

        // Program: jump whose target comes from a register.
        rst_n = 1'b0;
        step(1);
        clear_prog();
        prog[0]  = 16'h2028;                         // A += 40
        prog[1]  = 16'h8000;                         // IP <= A
        prog[40] = 16'h6007;                         // B += 7
        prog[41] = 16'hA029;                         // IP <= 41
        load_prog();
        rst_n = 1'b1;
        step(1); chk("R9 loaded word executes", acc_a, 16'd40);
        step(1); chk("R4 register-source jump", {10'h0, ip}, 16'd40);
                 chk("R4 register jump leaves B", acc_b, 16'd0);
        step(1); chk("R4 fetch from jump target", acc_b, 16'd7);
        step(5);

        // Reset again without reloading: the stored program must survive.
        rst_n = 1'b0;
        step(2);
        chk("R8 reset clears A", acc_a, 16'h0);
        rst_n = 1'b1;
        step(1); chk("R8 program kept across reset", acc_a, 16'd40);
        step(3);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule